// File: doc/BRIEF.md
# Radio Link Message Time Stamp Encoder

This block fills in the 6-bit time stamp field of each message that leaves a radio link transmitter. One message is described per cycle by a valid strobe, a two-bit message kind, start and end-of-packet flags, a payload byte count, a 4-bit address extension, a 13-bit message address and a radio frame boundary pulse. One cycle later the block presents the stamp, the address to send and a per-message error flag.

Antenna-carrier sample messages carry a running count. The count returns to zero on every radio frame boundary and advances once per sample message. Ethernet messages carry a marker for the first, a middle or the last message of a frame. The last marker also carries how many payload bytes hold MAC frame data. Generic packet messages carry a two-bit position marker followed by the address extension. That extension must not change within a packet, so the block holds the value taken at the start of the packet. An unused slot is sent with the reserved all-ones address.

Top module: `msg_tstamp_gen`

## Requirements
- R1: While reset is held and after its release, before any message, `out_vld`, `ts_out`, `addr_out` and `ext_err` are all zero.
- R2: Message kind codes are 00 empty slot, 01 antenna-carrier data, 10 Ethernet, 11 generic packet. Successive data messages are stamped 0, 1, 2, ... counting from reset.
- R3: A frame pulse with no data message makes the next data message stamp 0. A frame pulse that arrives together with a data message stamps that message 0, and the following data message gets 1.
- R4: The data count wraps from 63 to 0 when more than 64 data messages fall in one frame.
- R5: An Ethernet message marked start (and not end) is stamped 6'b100000. One marked neither start nor end is stamped 6'b000000.
- R6: An Ethernet message marked end is stamped {1'b1, byte_count[4:0]}. This also applies when it is marked start as well.
- R7: Generic packet messages are stamped {2'b10, ext} at start, {2'b00, ext} in the middle and {2'b11, ext} at end. A message marked both start and end is stamped {2'b11, ext}.
- R8: Middle and end messages of a generic packet carry the extension captured at its start. `ext_err` is 1 for exactly those messages whose extension input differs from that captured value, and 0 otherwise.
- R9: An empty slot message has `addr_out` = 13'h1FFF and `ts_out` = 0. Every other kind passes `msg_addr` through unchanged.
- R10: Empty, Ethernet and generic messages leave the data count unchanged.
- R11: `out_vld` is high in exactly the cycle after a cycle with `msg_vld` high. Stamp, address and flag hold their values while no message arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_vld | input | 1 | A message is described this cycle |
| msg_type | input | 2 | Message kind (00 empty, 01 data, 10 Ethernet, 11 generic) |
| pkt_sop | input | 1 | Message is first of a packet |
| pkt_eop | input | 1 | Message is last of a packet |
| eth_bytes | input | 5 | MAC data bytes in the last Ethernet message |
| addr_ext | input | 4 | Address extension for generic packets |
| msg_addr | input | 13 | Message address |
| frame_pulse | input | 1 | Radio frame boundary strobe |
| out_vld | output | 1 | Stamp and address are new this cycle |
| ts_out | output | 6 | Encoded time stamp |
| addr_out | output | 13 | Address to transmit |
| ext_err | output | 1 | Extension changed inside a generic packet |

## Verification
The properties assume that the packet flags and byte count are meaningful only with `msg_valid` high. They also assume that the message kind is one of the four defined codes, which holds by the width of the field. The extension checks take the start-of-packet value from the same cycle as the start message, so they assume a start message is not dropped before its middle messages. The directed stimulus always opens a generic packet with a start message. It changes the extension mid-packet only in the scenario built for that purpose, and it drives the frame pulse both alone and together with a data message.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    MK_EMPTY = 2'b00,
    MK_AXC   = 2'b01,
    MK_ETH   = 2'b10,
    MK_GEN   = 2'b11
  } msg_kind_e;
endpackage

// File: rtl/axc_seq_counter.sv
module axc_seq_counter #(
  parameter int TS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            restart,
  output logic [TS_W-1:0] cur
);
  logic [TS_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cur    = restart ? '0 : cnt_q;
    cnt_en = adv | restart;
    cnt_d  = adv ? cur + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gen_ext_tracker.sv
module gen_ext_tracker #(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_msg,
  input  logic             sop,
  input  logic             eop,
  input  logic [EXT_W-1:0] ext_in,
  output logic [EXT_W-1:0] ext_use,
  output logic             mismatch
);
  logic             open_q, open_d;
  logic [EXT_W-1:0] held_q, held_d;
  logic             upd_en;

  always_comb begin
    ext_use  = ext_in;
    mismatch = 1'b0;
    open_d   = open_q;
    held_d   = held_q;
    upd_en   = gen_msg;
    if (gen_msg) begin
      if (sop) begin
        held_d = ext_in;
        open_d = !eop;
      end else if (open_q) begin
        ext_use  = held_q;
        mismatch = (ext_in != held_q);
        open_d   = !eop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      held_q <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/ts_field_encoder.sv
module ts_field_encoder
  import ts_pkg::*;
#(
  parameter int TS_W   = 6,
  parameter int ADDR_W = 13,
  localparam int BYTE_W = TS_W - 1,
  localparam int EXT_W  = TS_W - 2
) (
  input  msg_kind_e         kind,
  input  logic              sop,
  input  logic              eop,
  input  logic [TS_W-1:0]   axc_cnt,
  input  logic [BYTE_W-1:0] bytes,
  input  logic [EXT_W-1:0]  ext,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [TS_W-1:0]   ts,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    ts   = '0;
    addr = addr_in;
    unique case (kind)
      MK_EMPTY: addr = '1;
      MK_AXC:   ts = axc_cnt;
      MK_ETH: begin
        if (eop)      ts = {1'b1, bytes};
        else if (sop) ts = {1'b1, {BYTE_W{1'b0}}};
        else          ts = '0;
      end
      MK_GEN: begin
        if (eop)      ts = {2'b11, ext};
        else if (sop) ts = {2'b10, ext};
        else          ts = {2'b00, ext};
      end
    endcase
  end
endmodule

// File: rtl/msg_tstamp_gen.sv
module msg_tstamp_gen
  import ts_pkg::*;
#(
  parameter int TS_W   = 6,
  parameter int ADDR_W = 13,
  localparam int BYTE_W = TS_W - 1,
  localparam int EXT_W  = TS_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_vld,
  input  logic [1:0]        msg_type,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  input  logic [BYTE_W-1:0] eth_bytes,
  input  logic [EXT_W-1:0]  addr_ext,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic              frame_pulse,
  output logic              out_vld,
  output logic [TS_W-1:0]   ts_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              ext_err
);
  msg_kind_e         kind;
  logic              axc_adv, gen_msg, mism;
  logic [TS_W-1:0]   axc_cur, ts_d;
  logic [EXT_W-1:0]  ext_use;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    kind    = msg_kind_e'(msg_type);
    axc_adv = msg_vld && (kind == MK_AXC);
    gen_msg = msg_vld && (kind == MK_GEN);
  end

  axc_seq_counter #(.TS_W(TS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(axc_adv), .restart(frame_pulse), .cur(axc_cur)
  );

  gen_ext_tracker #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .gen_msg(gen_msg), .sop(pkt_sop), .eop(pkt_eop),
    .ext_in(addr_ext), .ext_use(ext_use), .mismatch(mism)
  );

  ts_field_encoder #(.TS_W(TS_W), .ADDR_W(ADDR_W)) u_enc (
    .kind(kind), .sop(pkt_sop), .eop(pkt_eop), .axc_cnt(axc_cur), .bytes(eth_bytes),
    .ext(ext_use), .addr_in(msg_addr), .ts(ts_d), .addr(addr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= msg_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_out   <= '0;
      addr_out <= '0;
      ext_err  <= 1'b0;
    end else if (msg_vld) begin
      ts_out   <= ts_d;
      addr_out <= addr_d;
      ext_err  <= mism;
    end
  end
endmodule

// File: rtl/ts_gen_chk.sv
module ts_gen_chk #(
  parameter int TS_W   = 6,
  parameter int ADDR_W = 13,
  localparam int BYTE_W = TS_W - 1,
  localparam int EXT_W  = TS_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_vld,
  input logic [1:0]        msg_type,
  input logic              pkt_sop,
  input logic              pkt_eop,
  input logic [BYTE_W-1:0] eth_bytes,
  input logic [EXT_W-1:0]  addr_ext,
  input logic [ADDR_W-1:0] msg_addr,
  input logic              frame_pulse,
  input logic              out_vld,
  input logic [TS_W-1:0]   ts_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic              ext_err
);
  assert_empty_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_type == 2'b00) |=> (addr_out == '1 && ts_out == '0));

  assert_pass_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_type != 2'b00) |=> (addr_out == $past(msg_addr)));

  assert_frame_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_type == 2'b01 && frame_pulse) |=> (ts_out == '0));

  assert_eth_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_type == 2'b10 && pkt_sop && !pkt_eop) |=> (ts_out == {1'b1, {BYTE_W{1'b0}}}));

  assert_eth_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_type == 2'b10 && pkt_eop) |=> (ts_out == {1'b1, $past(eth_bytes)}));

  assert_gen_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_type == 2'b11 && pkt_sop && !pkt_eop) |=>
      (ts_out == {2'b10, $past(addr_ext)} && !ext_err));

  assert_out_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_vld |=> out_vld);

  assert_out_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_vld |=> (!out_vld && $stable(ts_out) && $stable(addr_out)));
endmodule

bind msg_tstamp_gen ts_gen_chk #(.TS_W(TS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_type(msg_type),
  .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .eth_bytes(eth_bytes), .addr_ext(addr_ext),
  .msg_addr(msg_addr), .frame_pulse(frame_pulse), .out_vld(out_vld), .ts_out(ts_out),
  .addr_out(addr_out), .ext_err(ext_err)
);

// File: tb/msg_tstamp_gen_tb.sv
`timescale 1ns/1ps
module msg_tstamp_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_vld;
  logic [1:0]  msg_type;
  logic        pkt_sop, pkt_eop;
  logic [4:0]  eth_bytes;
  logic [3:0]  addr_ext;
  logic [12:0] msg_addr;
  logic        frame_pulse;
  logic        out_vld;
  logic [5:0]  ts_out;
  logic [12:0] addr_out;
  logic        ext_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msg_tstamp_gen u_dut (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_type(msg_type),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .eth_bytes(eth_bytes), .addr_ext(addr_ext),
    .msg_addr(msg_addr), .frame_pulse(frame_pulse), .out_vld(out_vld), .ts_out(ts_out),
    .addr_out(addr_out), .ext_err(ext_err)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive one message at a falling edge; results are read at the next falling edge.
  task automatic send(input logic [1:0] k, input logic s, input logic e, input logic [4:0] b,
                      input logic [3:0] x, input logic [12:0] a, input logic f);
    @(negedge clk);
    msg_vld = 1'b1; msg_type = k; pkt_sop = s; pkt_eop = e;
    eth_bytes = b; addr_ext = x; msg_addr = a; frame_pulse = f;
    @(negedge clk);
    msg_vld = 1'b0; frame_pulse = 1'b0;
  endtask

  task automatic pulse_only();
    @(negedge clk);
    msg_vld = 1'b0; frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_vld", out_vld, 0);
    chk("R1 ts_out", ts_out, 0);
    chk("R1 addr_out", addr_out, 0);
    chk("R1 ext_err", ext_err, 0);
  endtask

  task automatic t_count();
    send(2'b01, 0, 0, 0, 0, 13'h010, 0); chk("R2 first", ts_out, 0);
    send(2'b01, 0, 0, 0, 0, 13'h010, 0); chk("R2 second", ts_out, 1);
    send(2'b01, 0, 0, 0, 0, 13'h010, 0); chk("R2 third", ts_out, 2);
    pulse_only();
    send(2'b01, 0, 0, 0, 0, 13'h010, 0); chk("R3 after lone pulse", ts_out, 0);
  endtask

  task automatic t_frame_coincident();
    send(2'b01, 0, 0, 0, 0, 13'h011, 0); chk("R3 pre", ts_out, 1);
    send(2'b01, 0, 0, 0, 0, 13'h011, 1); chk("R3 coincident", ts_out, 0);
    send(2'b01, 0, 0, 0, 0, 13'h011, 0); chk("R3 following", ts_out, 1);
  endtask

  task automatic t_wrap();
    pulse_only();
    for (int i = 0; i < 64; i++) send(2'b01, 0, 0, 0, 0, 13'h020, 0);
    chk("R4 last in range", ts_out, 63);
    send(2'b01, 0, 0, 0, 0, 13'h020, 0); chk("R4 wrapped", ts_out, 0);
  endtask

  task automatic t_eth();
    send(2'b10, 1, 0, 5'd9, 0, 13'h100, 0); chk("R5 start", ts_out, 32);
    send(2'b10, 0, 0, 5'd9, 0, 13'h100, 0); chk("R5 middle", ts_out, 0);
    send(2'b10, 0, 1, 5'd13, 0, 13'h100, 0); chk("R6 end", ts_out, 45);
    send(2'b10, 1, 1, 5'd5, 0, 13'h100, 0); chk("R6 single", ts_out, 37);
  endtask

  task automatic t_generic();
    send(2'b11, 1, 0, 0, 4'd9, 13'h200, 0); chk("R7 start", ts_out, 41);
    send(2'b11, 0, 0, 0, 4'd9, 13'h200, 0); chk("R7 middle", ts_out, 9);
    send(2'b11, 0, 1, 0, 4'd9, 13'h200, 0); chk("R7 end", ts_out, 57);
    send(2'b11, 1, 1, 0, 4'd3, 13'h200, 0); chk("R7 single", ts_out, 51);
  endtask

  task automatic t_ext_err();
    send(2'b11, 1, 0, 0, 4'd5, 13'h201, 0); chk("R8 start flag", ext_err, 0);
    send(2'b11, 0, 0, 0, 4'd10, 13'h201, 0);
    chk("R8 held ext", ts_out, 5); chk("R8 flag raised", ext_err, 1);
    send(2'b11, 0, 1, 0, 4'd5, 13'h201, 0);
    chk("R8 end ext", ts_out, 53); chk("R8 flag cleared", ext_err, 0);
  endtask

  task automatic t_empty();
    send(2'b00, 0, 0, 5'd7, 4'd7, 13'h123, 0);
    chk("R9 empty addr", addr_out, 13'h1FFF); chk("R9 empty ts", ts_out, 0);
    send(2'b01, 0, 0, 0, 0, 13'h0AB, 0); chk("R9 pass addr", addr_out, 13'h0AB);
  endtask

  task automatic t_no_advance();
    pulse_only();
    send(2'b01, 0, 0, 0, 0, 13'h030, 0); chk("R10 base", ts_out, 0);
    send(2'b10, 1, 1, 5'd2, 0, 13'h030, 0);
    send(2'b11, 1, 1, 0, 4'd1, 13'h030, 0);
    send(2'b00, 0, 0, 0, 0, 13'h030, 0);
    send(2'b01, 0, 0, 0, 0, 13'h030, 0); chk("R10 next data", ts_out, 1);
  endtask

  task automatic t_valid();
    send(2'b01, 0, 0, 0, 0, 13'h040, 0);
    chk("R11 valid", out_vld, 1);
    @(negedge clk);
    chk("R11 idle", out_vld, 0);
    chk("R11 hold addr", addr_out, 13'h040);
  endtask

  initial begin
    rst_n = 1'b0; msg_vld = 1'b0; msg_type = 2'b00; pkt_sop = 1'b0; pkt_eop = 1'b0;
    eth_bytes = '0; addr_ext = '0; msg_addr = '0; frame_pulse = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_frame_coincident();
    t_wrap();
    t_eth();
    t_generic();
    t_ext_err();
    t_empty();
    t_no_advance();
    t_valid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule